// File: doc/BRIEF.md
# Serial Receiver with Multi-Drop Wakeup

This block receives asynchronous serial characters from one input line. Each character has a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. The line is sampled on a 16x oversampling enable. Each finished character goes into a holding register. That register is presented as a valid/ready output stream, and an interrupt request follows it.

On a shared line, software can put the receiver in standby so that it ignores characters meant for other nodes. While in standby, characters are not loaded and the interrupt is masked. One control input chooses how the receiver leaves standby:

- **Idle-line wakeup:** the line stays high for a full character time.
- **Address-mark wakeup:** a character arrives whose top data bit is 1. That character is loaded.

Hardware clears standby when it wakes.

Back-pressure rules:

- `rx_valid` stays high, and `rx_data`, `rx_bit8` and `frame_err` stay stable, until a cycle where `rx_valid` and `rx_ready` are both high.
- The receive line cannot be stalled. A character that completes while an unconsumed one is held is dropped, and `overrun` is flagged.

Top module: `serial_rx_wake`

## Requirements
- R1: With `len9`=0 a frame is start(0), 8 data bits LSB first, stop(1); the byte appears on `rx_data` and `rx_bit8` reads 0.
- R2: With `len9`=1 a frame carries 9 data bits LSB first; bits 7..0 appear on `rx_data` and data bit 8 on `rx_bit8`.
- R3: Each bit lasts 16 `tick16` pulses after the first low sample. A bit's value is the majority of the samples at ticks 7, 8 and 9 of that bit. A start bit whose majority is high is discarded, so a low glitch shorter than 7 ticks loads nothing.
- R4: A completed character that is accepted loads the holding register and raises `rx_valid`. `irq` equals `rx_valid` while not in standby.
- R5: `rx_valid` falls the cycle after a handshake (`rx_valid` and `rx_ready` both 1) when no new character completes in that cycle. While `rx_ready` is 0 the held outputs do not change.
- R6: `frame_err` is 1 exactly when the stop bit of the held character was sampled low.
- R7: If a character completes while `rx_valid`=1 and no handshake occurs in that cycle, then:
  - `overrun` goes to 1;
  - the held character is kept;
  - the new character is dropped.

  A later handshake clears `overrun`.
- R8: A one-cycle pulse on `stby_set` sets `standby`. While in standby, `irq` is 0, and characters that do not wake the receiver are not loaded.
- R9: With `wake_addr`=0, standby ends once the line has been high for 160 consecutive ticks (8-bit) or 176 (9-bit), counted only from entering standby. No character is loaded by this wakeup.
- R10: With `wake_addr`=1, standby ends on a character whose top data bit (bit 7 for 8-bit, bit 8 for 9-bit) is 1, and that character is loaded. Characters with that bit 0 leave standby set.
- R11: After reset: `rx_valid`, `standby`, `irq`, `frame_err` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial receive line (idle high) |
| len9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_addr | input | 1 | 1 selects address-mark wakeup, 0 idle-line wakeup |
| stby_set | input | 1 | Pulse to enter standby |
| rx_ready | input | 1 | Consumer accepts the held character |
| rx_valid | output | 1 | Holding register is full |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_bit8 | output | 1 | Received data bit 8 (9-bit mode) |
| frame_err | output | 1 | Stop bit of held character was low |
| overrun | output | 1 | A character was lost while the register was full |
| standby | output | 1 | Receiver is in standby |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench targets the corner cases below. For each, it names the failure it would expose.

- **Short low glitch:** a design that skipped the mid-bit start check would load a phantom character.
- **Low stop bit:** a voter that misread the stop bit would lose the framing error. A design that failed to reject the start bit it then falsely sees would also load a phantom character.
- **Overrun with `rx_ready` held low:** this catches a design that overwrites the held byte or never clears the flag.
- **Idle-line threshold:** the bench probes just short of and just past the 10- and 11-bit-time thresholds, starting from an already idle line. This exposes off-by-one-bit counts and a counter that keeps history from before standby.
- **Address-mark wakeup in both lengths:** this exposes a check of the wrong top bit. It also catches a design that drops the waking character.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic       ferr;
    logic [8:0] bits;
  } rx_char_t;
endpackage

// File: rtl/rxw_sampler.sv
module rxw_sampler
  import rxw_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxd_s,
  input  logic     len9,
  output logic     done,
  output rx_char_t chr
);
  localparam int CW = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] SMP_A   = CW'(MID - 1);
  localparam logic [CW-1:0] SMP_B   = CW'(MID);
  localparam logic [CW-1:0] VOTE_AT = CW'(MID + 1);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);

  rx_state_e   st;
  logic [CW-1:0] cnt;
  logic [1:0]  smp;
  logic [3:0]  bidx;
  logic [8:0]  shr;
  logic        len9_q;
  logic        vote;
  logic [3:0]  last_bit;

  // majority of the two stored samples and the current one
  assign vote = (smp[1] & smp[0]) | (smp[1] & rxd_s) | (smp[0] & rxd_s);
  assign last_bit = len9_q ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      smp    <= '0;
      bidx   <= '0;
      shr    <= '0;
      len9_q <= 1'b0;
      done   <= 1'b0;
      chr    <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (st == ST_IDLE) begin
          if (!rxd_s) begin
            st     <= ST_START;
            cnt    <= '0;
            bidx   <= '0;
            len9_q <= len9;
          end
        end else begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt == SMP_A || cnt == SMP_B) smp <= {smp[0], rxd_s};
          if (cnt == VOTE_AT) begin
            case (st)
              ST_START: if (vote) st <= ST_IDLE;
              ST_DATA:  shr <= {vote, shr[8:1]};
              ST_STOP: begin
                done     <= 1'b1;
                chr.ferr <= ~vote;
                chr.bits <= len9_q ? shr : {1'b0, shr[8:1]};
                st       <= ST_IDLE;
              end
              default: ;
            endcase
          end
          if (cnt == LAST) begin
            if (st == ST_START) begin
              st <= ST_DATA;
            end else if (st == ST_DATA) begin
              if (bidx == last_bit) st <= ST_STOP;
              bidx <= bidx + 4'd1;
            end
          end
        end
      end
    end
  end

  // R3: completion is a single-cycle event
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3: a character can only complete out of the stop state
  a_r3_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == ST_IDLE) && $past(st == ST_STOP));
endmodule

// File: rtl/rxw_idle.sv
module rxw_idle #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd_s,
  input  logic len9,
  input  logic arm,
  output logic hit
);
  localparam int LIM8 = OSR * 10;
  localparam int LIM9 = OSR * 11;
  localparam int CW   = $clog2(LIM9 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = len9 ? CW'(LIM9) : CW'(LIM8);
  assign hit = arm && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!arm) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rxd_s)          cnt <= '0;
      else if (cnt < lim)  cnt <= cnt + 1'b1;
    end
  end

  // R9: the high-time count never runs past the longer threshold
  a_r9_idle_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIM9));
  // R9: a low line sample while armed restarts the count
  a_r9_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && tick && !rxd_s) |=> (cnt == '0));
endmodule

// File: rtl/rxw_wake.sv
module rxw_wake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_set,
  input  logic       wake_addr,
  input  logic       len9,
  input  logic       done,
  input  logic [8:0] bits,
  input  logic       idle_hit,
  output logic       stby,
  output logic       addr_hit
);
  logic msb;

  assign msb      = len9 ? bits[8] : bits[7];
  assign addr_hit = stby & wake_addr & done & msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    stby <= 1'b0;
    else if (stby_set)             stby <= 1'b1;
    else if (addr_hit || idle_hit) stby <= 1'b0;
  end

  // R10: a character without the address mark leaves standby set
  a_r10_no_mark_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && wake_addr && done && !(len9 ? bits[8] : bits[7]) && !idle_hit) |=> stby);
  // R8: standby only ends through one of the two wake conditions
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stby && !done && !idle_hit) |=> stby);
endmodule

// File: rtl/serial_rx_wake.sv
module serial_rx_wake
  import rxw_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       len9,
  input  logic       wake_addr,
  input  logic       stby_set,
  input  logic       rx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       frame_err,
  output logic       overrun,
  output logic       standby,
  output logic       irq
);
  logic [1:0] sync_q;
  logic       rxd_s;
  logic       chr_done;
  rx_char_t   chr;
  logic       idle_hit;
  logic       addr_hit;
  logic       load;
  logic       take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end
  assign rxd_s = sync_q[1];

  rxw_sampler #(.OSR(OSR)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s), .len9(len9),
    .done(chr_done), .chr(chr)
  );

  rxw_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd_s(rxd_s), .len9(len9),
    .arm(standby & ~wake_addr), .hit(idle_hit)
  );

  rxw_wake u_wake (
    .clk(clk), .rst_n(rst_n), .stby_set(stby_set), .wake_addr(wake_addr),
    .len9(len9), .done(chr_done), .bits(chr.bits), .idle_hit(idle_hit),
    .stby(standby), .addr_hit(addr_hit)
  );

  assign load = chr_done && (!standby || addr_hit);
  assign take = rx_valid && rx_ready;
  assign irq  = rx_valid && !standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_bit8   <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (load && (!rx_valid || rx_ready)) begin
        rx_valid  <= 1'b1;
        rx_data   <= chr.bits[7:0];
        rx_bit8   <= chr.bits[8];
        frame_err <= chr.ferr;
      end else if (take) begin
        rx_valid <= 1'b0;
      end
      if (load && rx_valid && !rx_ready) overrun <= 1'b1;
      else if (take)                     overrun <= 1'b0;
    end
  end

  // R4: an accepted character into an empty register sets valid
  a_r4_load_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && !standby && !rx_valid) |=> rx_valid);
  // R7: overrun keeps the held character and flags the loss
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && !standby && rx_valid && !rx_ready) |=> (overrun && $stable(rx_data) && $stable(rx_bit8)));
  // R5: a handshake with no new character empties the register
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !chr_done) |=> !rx_valid);
  // R5: back-pressure holds the presented character
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(frame_err)));
  // R8: a non-waking character in standby does not disturb the register
  a_r8_standby_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && chr_done && !addr_hit && !rx_valid) |=> !rx_valid);
endmodule

// File: tb/serial_rx_wake_tb.sv
`timescale 1ns/1ps
module serial_rx_wake_tb;
  localparam int TDIV = 4;
  localparam int BT   = 16 * TDIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16;
  logic rxd = 1'b1;
  logic len9 = 1'b0;
  logic wake_addr = 1'b0;
  logic stby_set = 1'b0;
  logic rx_ready = 1'b1;
  logic rx_valid;
  logic [7:0] rx_data;
  logic rx_bit8, frame_err, overrun, standby, irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] expq[$];
  logic [1:0] tdiv_q = '0;

  always #4 clk = ~clk;

  always @(posedge clk) tdiv_q <= tdiv_q + 2'd1;
  assign tick16 = (tdiv_q == 2'(TDIV - 1));

  serial_rx_wake u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .len9(len9),
    .wake_addr(wake_addr), .stby_set(stby_set), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .frame_err(frame_err), .overrun(overrun), .standby(standby), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every handshake
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rx_valid && rx_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4 unexpected character", {frame_err, rx_bit8, rx_data}, 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        check({frame_err, rx_bit8, rx_data} == e, "R1/R2/R6 scoreboard",
              {frame_err, rx_bit8, rx_data}, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: sends one frame, optionally pushing its expected result
  task automatic send(input logic [8:0] v, input bit nine, input bit stop, input bit expect_it);
    if (expect_it) expq.push_back({~stop, nine ? v[8] : 1'b0, v[7:0]});
    @(negedge clk);
    rxd = 1'b0; wait_clk(BT);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = v[i]; wait_clk(BT);
    end
    rxd = stop; wait_clk(BT);
    rxd = 1'b1;
    wait_clk(4);
  endtask

  task automatic enter_standby();
    @(negedge clk); stby_set = 1'b1;
    @(negedge clk); stby_set = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    // R11 reset state
    check(!rx_valid && !standby && !irq && !frame_err && !overrun, "R11 reset",
          {rx_valid, standby, irq, frame_err, overrun}, 0);
    wait_clk(BT);

    // R1 8-bit characters
    send(9'h055, 0, 1, 1);
    send(9'h0A3, 0, 1, 1);
    send(9'h000, 0, 1, 1);
    send(9'h0FF, 0, 1, 1);
    // R2 9-bit characters
    len9 = 1'b1;
    send(9'h1C4, 1, 1, 1);
    send(9'h03B, 1, 1, 1);
    len9 = 1'b0;
    wait_clk(BT);

    // R6 low stop bit, then the trailing false start must be rejected (R3)
    send(9'h081, 0, 0, 1);
    wait_clk(3 * BT);
    check(expq.size() == 0 && !rx_valid, "R6 framing char consumed, no phantom", expq.size(), 0);

    // R3 short glitch
    @(negedge clk); rxd = 1'b0; wait_clk(3 * TDIV); rxd = 1'b1;
    wait_clk(3 * BT);
    check(!rx_valid, "R3 glitch ignored", rx_valid, 0);

    // R4/R7 overrun under back-pressure
    rx_ready = 1'b0;
    send(9'h0C3, 0, 1, 1);
    check(rx_valid && irq, "R4 valid and irq", {rx_valid, irq}, 3);
    send(9'h01E, 0, 1, 0);
    check(overrun == 1'b1, "R7 overrun set", overrun, 1);
    check(rx_data == 8'hC3, "R7 older data kept", rx_data, 8'hC3);
    @(negedge clk); rx_ready = 1'b1;
    wait_clk(3);
    check(!overrun && !rx_valid, "R5/R7 read clears", {overrun, rx_valid}, 0);

    // R8 irq masked while a character is held in standby
    rx_ready = 1'b0;
    send(9'h066, 0, 1, 1);
    wake_addr = 1'b0;
    enter_standby();
    wait_clk(2);
    check(standby && rx_valid && !irq, "R8 irq masked", {standby, rx_valid, irq}, 6);
    wait_clk(12 * BT);
    check(!standby && irq, "R9 idle wake restores irq", {standby, irq}, 1);
    @(negedge clk); rx_ready = 1'b1;
    wait_clk(3);

    // R9 idle wake, 8-bit: counted from standby entry
    enter_standby();
    wait_clk(9 * BT);
    check(standby, "R9 still standby at 9 bit times", standby, 1);
    wait_clk(2 * BT);
    check(!standby, "R9 woke by 11 bit times", standby, 0);

    // R8/R9 non-waking traffic in standby, then idle wake
    enter_standby();
    send(9'h012, 0, 1, 0);
    check(standby && !rx_valid, "R8 char ignored in standby", {standby, rx_valid}, 2);
    wait_clk(8 * BT);
    check(standby, "R9 8-bit below threshold", standby, 1);
    wait_clk(2 * BT);
    check(!standby && !rx_valid, "R9 8-bit woke, nothing loaded", {standby, rx_valid}, 0);

    // R9 idle wake, 9-bit
    len9 = 1'b1;
    enter_standby();
    send(9'h0AA, 1, 1, 0);
    wait_clk(9 * BT);
    check(standby, "R9 9-bit below threshold", standby, 1);
    wait_clk(2 * BT);
    check(!standby, "R9 9-bit woke", standby, 0);

    // R10 address mark, 9-bit: bit 8 is the mark
    wake_addr = 1'b1;
    enter_standby();
    send(9'h0FF, 1, 1, 0);
    check(standby && !rx_valid, "R10 9-bit no mark", {standby, rx_valid}, 2);
    send(9'h13C, 1, 1, 1);
    check(!standby, "R10 9-bit mark wakes", standby, 0);
    len9 = 1'b0;

    // R10 address mark, 8-bit: bit 7 is the mark
    enter_standby();
    send(9'h07F, 0, 1, 0);
    check(standby, "R10 8-bit no mark", standby, 1);
    send(9'h091, 0, 1, 1);
    check(!standby, "R10 8-bit mark wakes", standby, 0);
    wait_clk(BT);
    check(expq.size() == 0, "R4 scoreboard drained", expq.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule